// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits at the front of a behavioural NOR flash model. It watches synchronous bus write strobes, each carrying an address and a data value, and recognises the keyed multi-write command sequences the array understands. When a sequence completes, it raises a single-cycle request for the array engine. The request carries a kind code, the write address and data, and, for a resume, the plane number. The decoder also holds two sticky modes: a bypass mode in which every later write becomes a program request, and an identification mode flag for the read path.

Every multi-write command starts with the same two-write unlock prefix. The third write selects a program, the identification commands, or the longer erase family. The erase family repeats the unlock prefix and then finishes with a chip erase, a sector erase, a sector lock or bypass entry. Suspend, resume and the short identification exit are single writes taken from idle. Any write that breaks a sequence sends the decoder back to idle without a request. The engine's `busy` input makes the decoder ignore every write while an embedded program is running.

States: `ST_IDLE`, `ST_KEY1` (first key seen), `ST_KEY2` (prefix complete), `ST_PROG_ARM` (program armed), `ST_ERS_80` (erase family opened), `ST_ERS_KEY1`, `ST_ERS_KEY2` (second prefix complete). Transitions: IDLE→KEY1 on the first key. KEY1→KEY2 on the second key. KEY2→PROG_ARM on A0. KEY2→ERS_80 on 80. KEY2→IDLE on 90 or F0, issuing a request. PROG_ARM→IDLE on any write, issuing a program. ERS_80→ERS_KEY1→ERS_KEY2 on the repeated keys. ERS_KEY2→IDLE on the final write. Any state goes to KEY1 on a mismatching first key, and otherwise to IDLE on a mismatch.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `req_valid`, `bypass_mode` and `id_mode` are 0 and the decoder is idle.
- R2: The unlock prefix is data AA at key address 5555 followed by data 55 at key address 2AAA. A write that does not match the expected key returns the decoder to idle with no request. If that write is AA at 5555, it starts a new sequence instead.
- R3: Prefix, then A0 at 5555, then any write produces a program request (kind 0) with that write's address and data.
- R4: Prefix, 80 at 5555, prefix, then 10 at 5555 gives chip erase (kind 2). Ending instead with 30 at any address gives sector erase (kind 1) carrying that address. A final 10 at an address other than 5555 gives no request.
- R5: Prefix, 80 at 5555, prefix, then 40 at 5555 sets `bypass_mode` with no request. While it is set, every accepted write, whatever its value, gives a program request (kind 0).
- R6: `bypass_mode` is cleared only by reset. One clock of reset low is enough.
- R7: Prefix then 90 at 5555 gives identification entry (kind 6) and sets `id_mode`. Prefix then F0 at 5555, or a single F0 at any address from idle, gives identification exit (kind 7) and clears `id_mode`.
- R8: From idle, a single B0 at any address gives erase suspend (kind 4). A single 30 at any address gives erase resume (kind 5), with `req_plane` equal to the top `PLANE_W` address bits. `req_plane` is 0 for every other kind.
- R9: Only address bits [15:0] and data bits [7:0] take part in key and code matching.
- R10: A write with `busy` high is ignored. It gives no request and does not advance the sequence.
- R11: Prefix, 80 at 5555, prefix, then 60 at any address gives sector lock (kind 3) carrying that address.
- R12: A request is visible in the clock cycle after the accepting edge and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| busy | input | 1 | Embedded program in progress; writes ignored |
| req_valid | output | 1 | One-cycle request pulse |
| req_kind | output | 3 | Request kind code (0..7) |
| req_addr | output | ADDR_W | Address of the completing write |
| req_data | output | DATA_W | Data of the completing write |
| req_plane | output | PLANE_W | Plane number for resume, else 0 |
| bypass_mode | output | 1 | Single-write program mode active |
| id_mode | output | 1 | Identification mode active |

## Verification
The bench builds the decoder with ADDR_W = 20, DATA_W = 16 and PLANE_W = 4, so both buses are wider than the compared key fields. With this build, writes whose upper address and data bits are nonzero still have to match, which checks that only the low fields are compared. A resume at an address whose top nibble is not zero shows that the plane number comes from the highest bits. Bypass mode is checked last in the run, and then a reset pulse shows that normal decoding comes back.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int KEY_AW = 16;
    localparam int KEY_DW = 8;

    localparam logic [KEY_AW-1:0] KEY_ADDR_A = 16'h5555;
    localparam logic [KEY_AW-1:0] KEY_ADDR_B = 16'h2AAA;

    localparam logic [KEY_DW-1:0] CODE_K1      = 8'hAA;
    localparam logic [KEY_DW-1:0] CODE_K2      = 8'h55;
    localparam logic [KEY_DW-1:0] CODE_PROG    = 8'hA0;
    localparam logic [KEY_DW-1:0] CODE_ERASE   = 8'h80;
    localparam logic [KEY_DW-1:0] CODE_CHIP    = 8'h10;
    localparam logic [KEY_DW-1:0] CODE_SECTOR  = 8'h30;
    localparam logic [KEY_DW-1:0] CODE_LOCK    = 8'h60;
    localparam logic [KEY_DW-1:0] CODE_BYPASS  = 8'h40;
    localparam logic [KEY_DW-1:0] CODE_ID_IN   = 8'h90;
    localparam logic [KEY_DW-1:0] CODE_ID_OUT  = 8'hF0;
    localparam logic [KEY_DW-1:0] CODE_SUSPEND = 8'hB0;

    typedef enum logic [2:0] {
        REQ_PROGRAM  = 3'd0,
        REQ_SECTOR   = 3'd1,
        REQ_CHIP     = 3'd2,
        REQ_LOCK     = 3'd3,
        REQ_SUSPEND  = 3'd4,
        REQ_RESUME   = 3'd5,
        REQ_ID_ENTER = 3'd6,
        REQ_ID_EXIT  = 3'd7
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG_ARM,
        ST_ERS_80,
        ST_ERS_KEY1,
        ST_ERS_KEY2
    } seq_state_e;

endpackage

// File: rtl/cmd_key_match.sv
module cmd_key_match
    import flash_cmd_pkg::*;
(
    input  logic [KEY_AW-1:0] addr_lo,
    input  logic [KEY_DW-1:0] data_lo,
    output logic              at_key_a,
    output logic              at_key_b,
    output logic [KEY_DW-1:0] code
);

    assign at_key_a = (addr_lo == KEY_ADDR_A);
    assign at_key_b = (addr_lo == KEY_ADDR_B);
    assign code     = data_lo;

endmodule

// File: rtl/cmd_mode_flags.sv
module cmd_mode_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_bypass,
    input  logic set_id,
    input  logic clr_id,
    output logic bypass_mode,
    output logic id_mode
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bypass_mode <= 1'b0;
            id_mode     <= 1'b0;
        end else begin
            if (set_bypass)
                bypass_mode <= 1'b1;
            if (set_id)
                id_mode <= 1'b1;
            else if (clr_id)
                id_mode <= 1'b0;
        end
    end

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 16,
    parameter int PLANE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              busy,
    input  logic              bypass,
    input  logic              at_key_a,
    input  logic              at_key_b,
    input  logic [KEY_DW-1:0] code,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              req_valid,
    output req_kind_e         req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [PLANE_W-1:0] req_plane,
    output logic              set_bypass,
    output logic              set_id,
    output logic              clr_id
);

    seq_state_e state, nxt_state;
    logic       fire;
    req_kind_e  kind;
    logic       accept;
    logic       restart;
    seq_state_e miss_state;

    assign accept     = wr_stb && !busy;
    assign restart    = at_key_a && (code == CODE_K1);
    assign miss_state = restart ? ST_KEY1 : ST_IDLE;

    always_comb begin
        nxt_state  = state;
        fire       = 1'b0;
        kind       = REQ_PROGRAM;
        set_bypass = 1'b0;
        if (accept) begin
            if (bypass) begin
                fire      = 1'b1;
                kind      = REQ_PROGRAM;
                nxt_state = ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (restart) begin
                            nxt_state = ST_KEY1;
                        end else if (code == CODE_SUSPEND) begin
                            fire = 1'b1;
                            kind = REQ_SUSPEND;
                        end else if (code == CODE_SECTOR) begin
                            fire = 1'b1;
                            kind = REQ_RESUME;
                        end else if (code == CODE_ID_OUT) begin
                            fire = 1'b1;
                            kind = REQ_ID_EXIT;
                        end
                    end
                    ST_KEY1: begin
                        nxt_state = (at_key_b && code == CODE_K2) ? ST_KEY2 : miss_state;
                    end
                    ST_KEY2: begin
                        nxt_state = miss_state;
                        if (at_key_a) begin
                            if (code == CODE_PROG) begin
                                nxt_state = ST_PROG_ARM;
                            end else if (code == CODE_ERASE) begin
                                nxt_state = ST_ERS_80;
                            end else if (code == CODE_ID_IN) begin
                                nxt_state = ST_IDLE;
                                fire      = 1'b1;
                                kind      = REQ_ID_ENTER;
                            end else if (code == CODE_ID_OUT) begin
                                nxt_state = ST_IDLE;
                                fire      = 1'b1;
                                kind      = REQ_ID_EXIT;
                            end
                        end
                    end
                    ST_PROG_ARM: begin
                        nxt_state = ST_IDLE;
                        fire      = 1'b1;
                        kind      = REQ_PROGRAM;
                    end
                    ST_ERS_80: begin
                        nxt_state = restart ? ST_ERS_KEY1 : ST_IDLE;
                    end
                    ST_ERS_KEY1: begin
                        nxt_state = (at_key_b && code == CODE_K2) ? ST_ERS_KEY2 : miss_state;
                    end
                    ST_ERS_KEY2: begin
                        nxt_state = ST_IDLE;
                        if (at_key_a && code == CODE_CHIP) begin
                            fire = 1'b1;
                            kind = REQ_CHIP;
                        end else if (code == CODE_SECTOR) begin
                            fire = 1'b1;
                            kind = REQ_SECTOR;
                        end else if (code == CODE_LOCK) begin
                            fire = 1'b1;
                            kind = REQ_LOCK;
                        end else if (at_key_a && code == CODE_BYPASS) begin
                            set_bypass = 1'b1;
                        end else begin
                            nxt_state = miss_state;
                        end
                    end
                    default: nxt_state = ST_IDLE;
                endcase
            end
        end
    end

    assign set_id = fire && (kind == REQ_ID_ENTER);
    assign clr_id = fire && (kind == REQ_ID_EXIT);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_kind  <= REQ_PROGRAM;
            req_addr  <= '0;
            req_data  <= '0;
            req_plane <= '0;
        end else begin
            req_valid <= fire;
            if (fire) begin
                req_kind  <= kind;
                req_addr  <= wr_addr;
                req_data  <= wr_data;
                req_plane <= (kind == REQ_RESUME) ? wr_addr[ADDR_W-1 -: PLANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 16,
    parameter int PLANE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               busy,
    output logic               req_valid,
    output logic [2:0]         req_kind,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [DATA_W-1:0]  req_data,
    output logic [PLANE_W-1:0] req_plane,
    output logic               bypass_mode,
    output logic               id_mode
);

    logic              at_key_a, at_key_b;
    logic [KEY_DW-1:0] code;
    logic              set_bypass, set_id, clr_id;
    req_kind_e         kind_q;

    cmd_key_match i_match (
        .addr_lo  (wr_addr[KEY_AW-1:0]),
        .data_lo  (wr_data[KEY_DW-1:0]),
        .at_key_a (at_key_a),
        .at_key_b (at_key_b),
        .code     (code)
    );

    cmd_seq_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PLANE_W (PLANE_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .busy       (busy),
        .bypass     (bypass_mode),
        .at_key_a   (at_key_a),
        .at_key_b   (at_key_b),
        .code       (code),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .req_valid  (req_valid),
        .req_kind   (kind_q),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_plane  (req_plane),
        .set_bypass (set_bypass),
        .set_id     (set_id),
        .clr_id     (clr_id)
    );

    assign req_kind = kind_q;

    cmd_mode_flags i_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_bypass  (set_bypass),
        .set_id      (set_id),
        .clr_id      (clr_id),
        .bypass_mode (bypass_mode),
        .id_mode     (id_mode)
    );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int PLANE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_stb,
    input logic               busy,
    input logic               req_valid,
    input logic [2:0]         req_kind,
    input logic [PLANE_W-1:0] req_plane,
    input logic               bypass_mode,
    input logic               id_mode
);

    p_busy_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && busy) |=> !req_valid);

    p_req_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(wr_stb && !busy));

    p_bypass_program_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_mode && wr_stb && !busy) |=> (req_valid && req_kind == 3'd0));

    p_bypass_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_mode |=> bypass_mode);

    p_id_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> (req_valid && req_kind == 3'd6));

    p_id_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_mode) |-> (req_valid && req_kind == 3'd7));

    p_plane_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != 3'd5) |-> (req_plane == '0));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.PLANE_W(PLANE_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .busy        (busy),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_plane   (req_plane),
    .bypass_mode (bypass_mode),
    .id_mode     (id_mode)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic          req_valid;
    logic [2:0]    req_kind;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic [PW-1:0] req_plane;
    logic          bypass_mode;
    logic          id_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic          got_v;
    logic [2:0]    got_k;
    logic [AW-1:0] got_a;
    logic [DW-1:0] got_d;
    logic [PW-1:0] got_p;

    always #4 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .PLANE_W(PW)) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_data(req_data), .req_plane(req_plane), .bypass_mode(bypass_mode), .id_mode(id_mode)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
        got_v = req_valid;
        got_k = req_kind;
        got_a = req_addr;
        got_d = req_data;
        got_p = req_plane;
    endtask

    task automatic prefix();
        wr(20'h05555, 16'h00AA);
        wr(20'h02AAA, 16'h0055);
    endtask

    task automatic erase_family();
        prefix();
        wr(20'h05555, 16'h0080);
        prefix();
    endtask

    task automatic expect_req(input string tag, input logic [2:0] k);
        chk(got_v === 1'b1, tag, got_v, 1);
        chk(got_k === k, tag, got_k, k);
    endtask

    task automatic expect_none(input string tag);
        chk(got_v === 1'b0, tag, got_v, 0);
    endtask

    task automatic t_reset();
        chk(req_valid === 1'b0, "R1 req_valid", req_valid, 0);
        chk(bypass_mode === 1'b0, "R1 bypass_mode", bypass_mode, 0);
        chk(id_mode === 1'b0, "R1 id_mode", id_mode, 0);
    endtask

    task automatic t_program();
        prefix();
        expect_none("R2 prefix no request");
        wr(20'h05555, 16'h00A0);
        expect_none("R3 armed no request");
        wr(20'h01234, 16'h5A5A);
        expect_req("R3 program", 3'd0);
        chk(got_a === 20'h01234, "R3 addr", got_a, 20'h01234);
        chk(got_d === 16'h5A5A, "R3 data", got_d, 16'h5A5A);
        @(negedge clk);
        chk(req_valid === 1'b0, "R12 one cycle", req_valid, 0);
    endtask

    task automatic t_mismatch();
        prefix();
        wr(20'h02AAA, 16'h0055);
        expect_none("R2 mismatch");
        wr(20'h05555, 16'h00A0);
        wr(20'h00042, 16'h0011);
        expect_none("R2 back to idle");
        wr(20'h05555, 16'h00AA);
        wr(20'h05555, 16'h00AA);
        wr(20'h02AAA, 16'h0055);
        wr(20'h05555, 16'h00A0);
        wr(20'h00077, 16'h0033);
        expect_req("R2 restart on key", 3'd0);
    endtask

    task automatic t_mask();
        wr(20'hA5555, 16'h77AA);
        wr(20'h32AAA, 16'hFF55);
        wr(20'hF5555, 16'h12A0);
        wr(20'hC1234, 16'hBEEF);
        expect_req("R9 masked compare", 3'd0);
        chk(got_a === 20'hC1234, "R9 addr", got_a, 20'hC1234);
    endtask

    task automatic t_erase();
        erase_family();
        wr(20'h05555, 16'h0010);
        expect_req("R4 chip erase", 3'd2);
        erase_family();
        wr(20'h47000, 16'h0030);
        expect_req("R4 sector erase", 3'd1);
        chk(got_a === 20'h47000, "R4 sector addr", got_a, 20'h47000);
        chk(got_p === 4'h0, "R8 plane zero", got_p, 0);
        erase_family();
        wr(20'h01111, 16'h0010);
        expect_none("R4 chip erase wrong addr");
        erase_family();
        wr(20'h7E000, 16'h0060);
        expect_req("R11 sector lock", 3'd3);
        chk(got_a === 20'h7E000, "R11 lock addr", got_a, 20'h7E000);
    endtask

    task automatic t_single();
        wr(20'h31234, 16'h00B0);
        expect_req("R8 suspend", 3'd4);
        wr(20'h9ABCD, 16'h0030);
        expect_req("R8 resume", 3'd5);
        chk(got_p === 4'h9, "R8 plane", got_p, 9);
    endtask

    task automatic t_ident();
        prefix();
        wr(20'h05555, 16'h0090);
        expect_req("R7 id entry", 3'd6);
        chk(id_mode === 1'b1, "R7 id_mode set", id_mode, 1);
        wr(20'h00123, 16'h00F0);
        expect_req("R7 short exit", 3'd7);
        chk(id_mode === 1'b0, "R7 id_mode clear", id_mode, 0);
        prefix();
        wr(20'h05555, 16'h0090);
        prefix();
        wr(20'h05555, 16'h00F0);
        expect_req("R7 long exit", 3'd7);
        chk(id_mode === 1'b0, "R7 id_mode clear long", id_mode, 0);
    endtask

    task automatic t_busy();
        busy = 1'b1;
        wr(20'h05555, 16'h00AA);
        expect_none("R10 busy key");
        busy = 1'b0;
        wr(20'h02AAA, 16'h0055);
        wr(20'h05555, 16'h00A0);
        wr(20'h00010, 16'h0001);
        expect_none("R10 busy did not advance");
        busy = 1'b1;
        wr(20'h00000, 16'h00B0);
        expect_none("R10 busy suspend");
        busy = 1'b0;
    endtask

    task automatic t_bypass();
        erase_family();
        wr(20'h05555, 16'h0040);
        expect_none("R5 bypass entry no request");
        chk(bypass_mode === 1'b1, "R5 bypass set", bypass_mode, 1);
        wr(20'h00200, 16'h00B0);
        expect_req("R5 B0 programs", 3'd0);
        chk(got_d === 16'h00B0, "R5 data", got_d, 16'h00B0);
        wr(20'h05555, 16'h00AA);
        expect_req("R5 AA programs", 3'd0);
        wr(20'h00300, 16'h00F0);
        expect_req("R5 F0 programs", 3'd0);
        chk(bypass_mode === 1'b1, "R6 still set", bypass_mode, 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(bypass_mode === 1'b0, "R6 cleared by reset", bypass_mode, 0);
        wr(20'h00200, 16'h00B0);
        expect_req("R6 normal after reset", 3'd4);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_mismatch();
        t_mask();
        t_erase();
        t_single();
        t_ident();
        t_busy();
        t_bypass();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            finish_run();
        end
    end

endmodule